// File: doc/BRIEF.md
# Outstanding Request Deadlock Watchdog

This block keeps watch over a small table of outstanding memory request slots and raises a sticky alarm when any of them has waited too long. Each slot records whether it is occupied, whether it carries a read-class or write-class request, and the cycle at which it was inserted. A free-running 32-bit cycle counter supplies the current time, and a threshold input sets the age at which a request is considered stuck. Ages are taken as unsigned 32-bit differences, so the counter may wrap.

The age check is not done every cycle. An insert that arrives while no check is pending arms one for a threshold period later. When the check fires, the block walks the slots one per cycle in ascending index order, and after the last slot it arms the next check one threshold period later only if requests are still outstanding; otherwise it goes idle until the next insert. The first stuck slot found is latched together with the alarm. Alongside, the block keeps its own outstanding counter and compares it with the number of occupied slots, latching an error on any disagreement, as happens when a slot is inserted twice or an empty slot is removed.

Top module: `req_deadlock_watchdog`

## Requirements
- R1: After reset the outstanding count is 0 and the scan-active, deadlock and count-error outputs are 0.
- R2: An insert (i_ins_valid with slot i_ins_slot, i_ins_write=1 for write class) occupies the slot and adds one to o_outstanding on the following cycle; a removal (i_rem_valid with i_rem_slot) frees it and subtracts one.
- R3: An insert accepted while the block is idle arms a check so that o_scan_active goes high exactly i_threshold cycles after the insert clock edge; inserts made while a check is already armed do not move it. The threshold must be nonzero.
- R4: A check visits each of the 8 slots once, one per cycle, in ascending index order, so o_scan_active stays high for exactly 8 cycles.
- R5: A visited occupied slot, read or write class, is stuck when the current time minus its insert time is at least i_threshold; the first stuck slot in visiting order sets o_deadlock and its index on o_dl_slot. A slot whose age is one less than the threshold is not flagged.
- R6: o_deadlock and o_dl_slot hold their values until reset; later stuck slots do not change the index.
- R7: At the last visit cycle the next check is armed one threshold period later if the outstanding count after that cycle's insert and removal is nonzero; otherwise no further check runs until a new insert.
- R8: o_count_err goes high and stays high when the internal outstanding count differs from the number of occupied slots, such as after inserting into an occupied slot or removing a free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_threshold | input | 32 | Age limit in cycles, nonzero |
| i_ins_valid | input | 1 | Insert a request this cycle |
| i_ins_slot | input | 3 | Slot receiving the insert |
| i_ins_write | input | 1 | Inserted request is write class (1) or read class (0) |
| i_rem_valid | input | 1 | Remove a request this cycle |
| i_rem_slot | input | 3 | Slot being freed |
| o_outstanding | output | 4 | Internal outstanding count |
| o_scan_active | output | 1 | A slot visit happens this cycle |
| o_deadlock | output | 1 | Sticky stuck-request alarm |
| o_dl_slot | output | 3 | Index of the first stuck slot found |
| o_count_err | output | 1 | Sticky count mismatch error |

## Verification
The re-arm decision taken on the last visit cycle can coincide with an insert or a removal that changes whether anything is still outstanding. The bench places a removal of the only remaining request exactly on that cycle and expects no further check at all, then, from an empty table, places an insert on that cycle and expects the next check to start exactly one threshold period after it. A second coincidence, an insert arriving while a check is already armed, is judged by the unchanged start cycle of the scan.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned TS_W = 32;

  typedef logic [TS_W-1:0] stamp_t;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_WAIT = 2'd1,
    WD_SCAN = 2'd2
  } wd_state_e;

  // Unsigned wraparound age of a request
  function automatic stamp_t age_of(stamp_t now_t, stamp_t issued_t);
    return now_t - issued_t;
  endfunction

  // A request is stuck once its age reaches the limit
  function automatic logic is_stuck(stamp_t now_t, stamp_t issued_t, stamp_t limit_t);
    return age_of(now_t, issued_t) >= limit_t;
  endfunction

  // Time at which the next check fires
  function automatic stamp_t due_after(stamp_t now_t, stamp_t limit_t);
    return now_t + limit_t;
  endfunction

endpackage

// File: rtl/wdog_cycle_timer.sv
module wdog_cycle_timer
  import wdog_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output stamp_t now
);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + stamp_t'(1);
  end

endmodule

// File: rtl/wdog_slot_table.sv
module wdog_slot_table
  import wdog_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_valid,
  input  logic [IDX_W-1:0]       ins_slot,
  input  logic                   ins_write,
  input  logic                   rem_valid,
  input  logic [IDX_W-1:0]       rem_slot,
  input  stamp_t                 now,
  output logic [SLOTS-1:0]       vld,
  output stamp_t [SLOTS-1:0]     stamp,
  output logic [CNT_W-1:0]       count_q,
  output logic [CNT_W-1:0]       count_d,
  output logic                   count_err
);

  logic [SLOTS-1:0] wr;
  logic [CNT_W-1:0] n_rd;
  logic [CNT_W-1:0] n_wr;
  logic             mismatch;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic take_ins;
      logic take_rem;
      assign take_ins = ins_valid && (ins_slot == IDX_W'(i));
      assign take_rem = rem_valid && (rem_slot == IDX_W'(i));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld[i]   <= 1'b0;
          wr[i]    <= 1'b0;
          stamp[i] <= '0;
        end else if (take_ins) begin
          vld[i]   <= 1'b1;
          wr[i]    <= ins_write;
          stamp[i] <= now;
        end else if (take_rem) begin
          vld[i]   <= 1'b0;
        end
      end
    end
  endgenerate

  // Counter kept separately from the slot bits, as a cross-check
  always_comb begin
    count_d = count_q + CNT_W'(ins_valid) - CNT_W'(rem_valid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  // Occupied read-class and write-class entries
  always_comb begin
    n_rd = '0;
    n_wr = '0;
    for (int k = 0; k < SLOTS; k++) begin
      n_rd = n_rd + CNT_W'(vld[k] & ~wr[k]);
      n_wr = n_wr + CNT_W'(vld[k] &  wr[k]);
    end
    mismatch = (count_q != (n_rd + n_wr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        count_err <= 1'b0;
    else if (mismatch) count_err <= 1'b1;
  end

endmodule

// File: rtl/wdog_scan_ctrl.sv
module wdog_scan_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stamp_t             now,
  input  stamp_t             thr,
  input  logic               ins_valid,
  input  logic [SLOTS-1:0]   vld,
  input  stamp_t [SLOTS-1:0] stamp,
  input  logic               busy_next,
  output logic               armed,
  output logic               scan_active,
  output logic               scan_last,
  output logic               hit,
  output logic               deadlock,
  output logic [IDX_W-1:0]   dl_slot
);

  wd_state_e        state_q;
  stamp_t           due_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    armed       = (state_q == WD_WAIT);
    scan_active = (state_q == WD_SCAN);
    scan_last   = scan_active && (idx_q == IDX_W'(SLOTS - 1));
    hit         = scan_active && vld[idx_q] && is_stuck(now, stamp[idx_q], thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WD_IDLE;
      due_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        WD_IDLE: begin
          if (ins_valid) begin
            due_q   <= due_after(now, thr);
            state_q <= WD_WAIT;
          end
        end
        WD_WAIT: begin
          if (now == due_q) begin
            idx_q   <= '0;
            state_q <= WD_SCAN;
          end
        end
        WD_SCAN: begin
          idx_q <= idx_q + IDX_W'(1);
          if (scan_last) begin
            if (busy_next) begin
              due_q   <= due_after(now, thr);
              state_q <= WD_WAIT;
            end else begin
              state_q <= WD_IDLE;
            end
          end
        end
        default: state_q <= WD_IDLE;
      endcase
    end
  end

  // First stuck slot wins, held until reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deadlock <= 1'b0;
      dl_slot  <= '0;
    end else if (hit && !deadlock) begin
      deadlock <= 1'b1;
      dl_slot  <= idx_q;
    end
  end

endmodule

// File: rtl/req_deadlock_watchdog.sv
module req_deadlock_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  i_threshold,
  input  logic             i_ins_valid,
  input  logic [IDX_W-1:0] i_ins_slot,
  input  logic             i_ins_write,
  input  logic             i_rem_valid,
  input  logic [IDX_W-1:0] i_rem_slot,
  output logic [CNT_W-1:0] o_outstanding,
  output logic             o_scan_active,
  output logic             o_deadlock,
  output logic [IDX_W-1:0] o_dl_slot,
  output logic             o_count_err
);

  stamp_t             w_now;
  logic [SLOTS-1:0]   w_vld;
  stamp_t [SLOTS-1:0] w_stamp;
  logic [CNT_W-1:0]   w_count;
  logic [CNT_W-1:0]   w_count_d;
  logic               w_count_err;
  logic               w_busy_next;
  logic               w_armed;
  logic               w_scan_active;
  logic               w_scan_last;
  logic               w_hit;
  logic               w_deadlock;
  logic [IDX_W-1:0]   w_dl_slot;

  wdog_cycle_timer u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .now   (w_now)
  );

  wdog_slot_table #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (i_ins_valid),
    .ins_slot  (i_ins_slot),
    .ins_write (i_ins_write),
    .rem_valid (i_rem_valid),
    .rem_slot  (i_rem_slot),
    .now       (w_now),
    .vld       (w_vld),
    .stamp     (w_stamp),
    .count_q   (w_count),
    .count_d   (w_count_d),
    .count_err (w_count_err)
  );

  assign w_busy_next = (w_count_d != '0);

  wdog_scan_ctrl #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W)
  ) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .now         (w_now),
    .thr         (i_threshold),
    .ins_valid   (i_ins_valid),
    .vld         (w_vld),
    .stamp       (w_stamp),
    .busy_next   (w_busy_next),
    .armed       (w_armed),
    .scan_active (w_scan_active),
    .scan_last   (w_scan_last),
    .hit         (w_hit),
    .deadlock    (w_deadlock),
    .dl_slot     (w_dl_slot)
  );

  assign o_outstanding = w_count;
  assign o_scan_active = w_scan_active;
  assign o_deadlock    = w_deadlock;
  assign o_dl_slot     = w_dl_slot;
  assign o_count_err   = w_count_err;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input stamp_t           thr,
  input logic             ins_valid,
  input logic             armed,
  input logic             scan_active,
  input logic             scan_last,
  input logic             busy_next,
  input logic             hit,
  input logic             deadlock,
  input logic [IDX_W-1:0] dl_slot,
  input logic [SLOTS-1:0] vld,
  input logic [CNT_W-1:0] count,
  input logic             count_err
);

  AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    thr != '0); // R3

  AST_INSERT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !armed && !scan_active) |=> armed); // R3

  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_last |=> !scan_active); // R4

  AST_FLAG_FROM_VISIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(hit)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> (deadlock && $stable(dl_slot))); // R6

  AST_REARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && busy_next) |=> armed); // R7

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && !busy_next) |=> (!armed && !scan_active)); // R7

  AST_COUNT_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(count_err) |-> $past(count != CNT_W'($countones(vld)))); // R8

  AST_COUNT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    count_err |=> count_err); // R8

endmodule

bind req_deadlock_watchdog wdog_checker #(
  .SLOTS (SLOTS),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr         (i_threshold),
  .ins_valid   (i_ins_valid),
  .armed       (w_armed),
  .scan_active (w_scan_active),
  .scan_last   (w_scan_last),
  .busy_next   (w_busy_next),
  .hit         (w_hit),
  .deadlock    (w_deadlock),
  .dl_slot     (w_dl_slot),
  .vld         (w_vld),
  .count       (w_count),
  .count_err   (w_count_err)
);

// File: tb/req_deadlock_watchdog_tb.sv
module req_deadlock_watchdog_tb;

  localparam int THR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] i_threshold = 32'(THR);
  logic        i_ins_valid = 1'b0;
  logic [2:0]  i_ins_slot = '0;
  logic        i_ins_write = 1'b0;
  logic        i_rem_valid = 1'b0;
  logic [2:0]  i_rem_slot = '0;
  logic [3:0]  o_outstanding;
  logic        o_scan_active;
  logic        o_deadlock;
  logic [2:0]  o_dl_slot;
  logic        o_count_err;

  int checks = 0;
  int errors = 0;
  int scan_starts = 0;
  logic prev_scan = 1'b0;

  req_deadlock_watchdog u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .i_threshold   (i_threshold),
    .i_ins_valid   (i_ins_valid),
    .i_ins_slot    (i_ins_slot),
    .i_ins_write   (i_ins_write),
    .i_rem_valid   (i_rem_valid),
    .i_rem_slot    (i_rem_slot),
    .o_outstanding (o_outstanding),
    .o_scan_active (o_scan_active),
    .o_deadlock    (o_deadlock),
    .o_dl_slot     (o_dl_slot),
    .o_count_err   (o_count_err)
  );

  always #5 clk = ~clk;

  // Count scan starts seen at the outputs
  always @(negedge clk) begin
    if (o_scan_active && !prev_scan) scan_starts = scan_starts + 1;
    prev_scan = o_scan_active;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    i_ins_valid = 1'b0;
    i_rem_valid = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  // Called at a negedge; the insert is taken by the next rising edge
  task automatic ins(int slot, bit wr);
    i_ins_valid = 1'b1;
    i_ins_slot  = 3'(slot);
    i_ins_write = wr;
    @(negedge clk);
    i_ins_valid = 1'b0;
  endtask

  task automatic rem(int slot);
    i_rem_valid = 1'b1;
    i_rem_slot  = 3'(slot);
    @(negedge clk);
    i_rem_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "outstanding", int'(o_outstanding), 0);
    chk("R1", "scan_active", int'(o_scan_active), 0);
    chk("R1", "deadlock", int'(o_deadlock), 0);
    chk("R1", "count_err", int'(o_count_err), 0);
  endtask

  task automatic t_count();
    do_reset();
    ins(0, 1'b0);
    ins(1, 1'b1);
    ins(2, 1'b0);
    chk("R2", "outstanding after 3 inserts", int'(o_outstanding), 3);
    rem(1);
    chk("R2", "outstanding after removal", int'(o_outstanding), 2);
    chk("R8", "no count error on clean traffic", int'(o_count_err), 0);
  endtask

  task automatic t_arm();
    do_reset();
    ins(0, 1'b0);
    idle(THR - 1);
    chk("R3", "scan not yet started", int'(o_scan_active), 0);
    idle(1);
    chk("R3", "scan starts threshold after insert", int'(o_scan_active), 1);
    idle(7);
    chk("R4", "scan still active at eighth cycle", int'(o_scan_active), 1);
    idle(1);
    chk("R4", "scan over after eight cycles", int'(o_scan_active), 0);
    // A later insert while armed must not move the check
    do_reset();
    ins(0, 1'b0);
    idle(4);
    ins(1, 1'b1);
    idle(THR - 6);
    chk("R3", "second insert keeps schedule (before)", int'(o_scan_active), 0);
    idle(1);
    chk("R3", "second insert keeps schedule (start)", int'(o_scan_active), 1);
  endtask

  task automatic t_quiet();
    int snap;
    do_reset();
    snap = scan_starts;
    ins(0, 1'b0);
    rem(0);
    idle(3 * THR);
    chk("R7", "single scan when table drained", scan_starts - snap, 1);
    chk("R5", "no flag for removed request", int'(o_deadlock), 0);
  endtask

  task automatic t_boundary();
    do_reset();
    ins(0, 1'b0);    // arms at E0
    rem(0);          // E1
    idle(2);
    ins(2, 1'b0);    // E4: age at its visit is THR-1
    ins(4, 1'b1);    // E5: age at its visit is THR
    idle(THR - 1);   // after E(THR+4)
    chk("R5", "no flag before slot 4 visited", int'(o_deadlock), 0);
    idle(4);         // after E(THR+8)
    chk("R5", "age equal to threshold flags", int'(o_deadlock), 1);
    chk("R5", "age one below threshold skipped", int'(o_dl_slot), 4);
  endtask

  task automatic t_sticky();
    int snap;
    do_reset();
    ins(6, 1'b1);
    idle(THR + 7);
    chk("R5", "write-class stuck slot flagged", int'(o_deadlock), 1);
    chk("R5", "write-class slot index", int'(o_dl_slot), 6);
    snap = scan_starts;
    ins(1, 1'b0);
    rem(6);
    idle(2 * THR + 10);
    chk("R7", "rescan while requests remain", int'(scan_starts - snap > 0), 1);
    chk("R6", "flag held", int'(o_deadlock), 1);
    chk("R6", "index held after later stuck slot", int'(o_dl_slot), 6);
  endtask

  task automatic t_same_cycle();
    int snap;
    do_reset();
    ins(3, 1'b0);    // E0
    idle(THR + 7);   // after E(THR+7)
    snap = scan_starts;
    rem(3);          // on the last visit edge E(THR+8)
    idle(2 * THR + 4);
    chk("R7", "removal on last visit stops checks", scan_starts - snap, 0);
    chk("R2", "outstanding back to zero", int'(o_outstanding), 0);
    do_reset();
    ins(3, 1'b0);    // E0
    rem(3);          // E1
    idle(THR + 6);   // after E(THR+7)
    ins(5, 1'b0);    // on the last visit edge E(THR+8)
    idle(THR - 1);
    chk("R7", "insert on last visit: not early", int'(o_scan_active), 0);
    idle(1);
    chk("R7", "insert on last visit re-arms", int'(o_scan_active), 1);
  endtask

  task automatic t_mismatch();
    do_reset();
    ins(2, 1'b0);
    ins(2, 1'b1);
    idle(1);
    chk("R8", "double insert outstanding", int'(o_outstanding), 2);
    chk("R8", "double insert raises error", int'(o_count_err), 1);
    idle(3);
    chk("R8", "error sticky", int'(o_count_err), 1);
    do_reset();
    rem(7);
    idle(1);
    chk("R8", "removing free slot raises error", int'(o_count_err), 1);
  endtask

  initial begin
    t_reset();
    t_count();
    t_arm();
    t_quiet();
    t_boundary();
    t_sticky();
    t_same_cycle();
    t_mismatch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule